// File: doc/BRIEF.md
# Dual-Channel Serial Bit Receiver with Dropout Fill

This block takes two one-bit data streams that arrive side by side on a shared parallel input port. An external strobe marks each bit slot. On each rising strobe edge, after synchronisation, the block samples one bit for each channel at the same instant. It shifts each channel's bits into a 16-bit word, most significant bit first. After the sixteenth slot both words appear together on the outputs with a single-cycle ready pulse.

A built-in watchdog protects the word cadence if the link drops out. Each accepted strobe restarts the watchdog with a long timeout of two nominal bit periods. If no strobe arrives before the timeout ends, the watchdog inserts a slot in which both channel bits are zero. It then keeps inserting zero slots once every nominal bit period until strobes return. Words therefore keep arriving at the normal rate during link loss.

The nominal bit rate and the system clock rate are parameters. The watchdog periods in clock cycles are derived from them. A status output shows whether the most recent slot came from the watchdog.

Top module: `dual_bit_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, `word0`, `word1`, `word_ready` and `from_watchdog` are all zero.
- R2: Channel 0 takes its bit from port bit 5 and channel 1 from port bit 6. The other port bits have no effect on either word.
- R3: One rising strobe edge is one slot for both channels, however long the strobe stays high. Strobes spaced closer than 2*BIT_CYC cycles never produce a watchdog slot.
- R4: A watchdog slot shifts a zero into both channels whatever the port holds. While strobes stay absent, watchdog slots repeat every BIT_CYC cycles, so words during a full dropout are zero and arrive every 16*BIT_CYC cycles.
- R5: After 16 slots, `word_ready` is high for exactly one cycle and both words update on that same cycle. The first slot's bit lands in bit 15 and the last slot's bit in bit 0.
- R6: Between ready pulses, `word0` and `word1` do not change, even while a new word is being collected.
- R7: `from_watchdog` is 1 exactly when the most recent slot was a watchdog slot. A strobe edge in the same cycle as a watchdog expiry counts as a strobe slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | PORT_W (8) | Shared data port; bit 5 feeds channel 0, bit 6 feeds channel 1 |
| strobe | input | 1 | Asynchronous bit-slot strobe, active on its rising edge |
| word0 | output | WORD_W (16) | Last completed channel 0 word |
| word1 | output | WORD_W (16) | Last completed channel 1 word |
| word_ready | output | 1 | One-cycle pulse when both words update |
| from_watchdog | output | 1 | Most recent slot was inserted by the watchdog |

## Verification
On every cycle, the checks cover the following:
- the ready pulse never lasts longer than one cycle;
- the words hold steady between pulses;
- the watchdog never fires earlier than two bit periods after a strobe;
- a strobe slot always clears the status flag;
- a word that completes on a watchdog slot ends in zero bits.

Only the bench scenarios can show the rest:
- the bit mapping from the port;
- the MSB-first ordering of complete words;
- a partly received word being finished with zeros;
- the exact 16-period spacing of words during a dropout;
- the absence of fill slots when strobes are slow but still inside the timeout.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
   typedef enum logic {
      SRC_STROBE   = 1'b0,
      SRC_WATCHDOG = 1'b1
   } slot_src_e;

   function automatic int cyc_per_bit(input int clk_hz, input int bit_hz);
      return clk_hz / bit_hz;
   endfunction
endpackage

// File: rtl/dbr_strobe_edge.sv
module dbr_strobe_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe_async,
   output logic edge_pulse
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dbr_strobe_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], strobe_async};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign edge_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dbr_watchdog.sv
module dbr_watchdog #(
   parameter int LONG_CYC  = 32,
   parameter int SHORT_CYC = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic kick,
   output logic fire
);
   localparam int CW = $clog2(LONG_CYC);

   logic [CW-1:0] remain_q;

   generate
      if (SHORT_CYC < 2 || LONG_CYC <= SHORT_CYC) begin : g_bad_periods
         $error("dbr_watchdog: need 2 <= SHORT_CYC < LONG_CYC");
      end
   endgenerate

   assign fire = (remain_q == '0) && !kick;

   always_ff @(posedge clk) begin
      if (rst) begin
         remain_q <= CW'(LONG_CYC - 1);
      end else if (kick) begin
         remain_q <= CW'(LONG_CYC - 1);
      end else if (fire) begin
         remain_q <= CW'(SHORT_CYC - 1);
      end else begin
         remain_q <= remain_q - 1'b1;
      end
   end
endmodule

// File: rtl/dbr_slot_counter.sv
module dbr_slot_counter #(
   parameter int SLOTS = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic slot,
   output logic last_slot
);
   localparam int CW = $clog2(SLOTS);

   logic [CW-1:0] idx_q;

   assign last_slot = slot && (idx_q == CW'(SLOTS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q <= '0;
      end else if (last_slot) begin
         idx_q <= '0;
      end else if (slot) begin
         idx_q <= idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/dbr_word_pack.sv
module dbr_word_pack #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              slot,
   input  logic              last_slot,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word_q
);
   logic [WORD_W-2:0] shift_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         shift_q <= '0;
         word_q  <= '0;
      end else if (slot) begin
         shift_q <= {shift_q[WORD_W-3:0], bit_in};
         if (last_slot) begin
            word_q <= {shift_q, bit_in};
         end
      end
   end
endmodule

// File: rtl/dual_bit_rx.sv
module dual_bit_rx #(
   parameter int PORT_W      = 8,
   parameter int CH0_POS     = 5,
   parameter int CH1_POS     = 6,
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int CLK_HZ      = 50_000_000,
   parameter int BIT_HZ      = 16384
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PORT_W-1:0] port_in,
   input  logic              strobe,
   output logic [WORD_W-1:0] word0,
   output logic [WORD_W-1:0] word1,
   output logic              word_ready,
   output logic              from_watchdog
);
   import dbr_pkg::*;

   localparam int BIT_CYC  = cyc_per_bit(CLK_HZ, BIT_HZ);
   localparam int GAP_LONG = 2 * BIT_CYC;
   localparam int NCH      = 2;
   localparam int CH_POS [NCH] = '{CH0_POS, CH1_POS};

   generate
      if (CH0_POS >= PORT_W || CH1_POS >= PORT_W || CH0_POS == CH1_POS) begin : g_bad_pos
         $error("dual_bit_rx: channel positions must be distinct and inside the port");
      end
      if (WORD_W < 4) begin : g_bad_word
         $error("dual_bit_rx: WORD_W must be at least 4");
      end
      if (BIT_CYC < 4) begin : g_bad_rate
         $error("dual_bit_rx: clock must be at least 4x the bit rate");
      end
   endgenerate

   logic      strb_pulse;
   logic      wd_fire;
   logic      slot;
   logic      last_slot;
   logic      ready_q;
   slot_src_e src_q;
   logic [WORD_W-1:0] words [NCH];

   dbr_strobe_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk          (clk),
      .rst          (rst),
      .strobe_async (strobe),
      .edge_pulse   (strb_pulse)
   );

   dbr_watchdog #(.LONG_CYC(GAP_LONG), .SHORT_CYC(BIT_CYC)) u_wd (
      .clk  (clk),
      .rst  (rst),
      .kick (strb_pulse),
      .fire (wd_fire)
   );

   assign slot = strb_pulse | wd_fire;

   dbr_slot_counter #(.SLOTS(WORD_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .slot      (slot),
      .last_slot (last_slot)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic ch_bit;
      assign ch_bit = strb_pulse & port_in[CH_POS[ch]];
      dbr_word_pack #(.WORD_W(WORD_W)) u_pack (
         .clk       (clk),
         .rst       (rst),
         .slot      (slot),
         .last_slot (last_slot),
         .bit_in    (ch_bit),
         .word_q    (words[ch])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ready_q <= 1'b0;
         src_q   <= SRC_STROBE;
      end else begin
         ready_q <= last_slot;
         if (slot) begin
            src_q <= strb_pulse ? SRC_STROBE : SRC_WATCHDOG;
         end
      end
   end

   assign word0         = words[0];
   assign word1         = words[1];
   assign word_ready    = ready_q;
   assign from_watchdog = (src_q == SRC_WATCHDOG);
endmodule

// File: rtl/dbr_chk.sv
module dbr_chk #(
   parameter int WORD_W   = 16,
   parameter int GAP_LONG = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              pulse,
   input logic              fire,
   input logic              ready,
   input logic              flag,
   input logic [WORD_W-1:0] w0,
   input logic [WORD_W-1:0] w1
);
   localparam int GW = $clog2(GAP_LONG + 1);

   logic [GW-1:0] since_q;

   always_ff @(posedge clk) begin
      if (rst || pulse) begin
         since_q <= '0;
      end else if (since_q != GW'(GAP_LONG)) begin
         since_q <= since_q + 1'b1;
      end
   end

   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
      ready |=> !ready); // R5
   AST_WORDS_HELD: assert property (@(posedge clk) disable iff (rst)
      !ready |-> ($stable(w0) && $stable(w1))); // R6
   AST_NO_EARLY_FIRE: assert property (@(posedge clk) disable iff (rst)
      fire |-> (since_q >= GW'(GAP_LONG - 1))); // R3
   AST_STROBE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
      pulse |=> !flag); // R7
   AST_FILL_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (ready && flag) |-> (!w0[0] && !w1[0])); // R4
endmodule

bind dual_bit_rx dbr_chk #(.WORD_W(WORD_W), .GAP_LONG(GAP_LONG)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .pulse (strb_pulse),
   .fire  (wd_fire),
   .ready (word_ready),
   .flag  (from_watchdog),
   .w0    (word0),
   .w1    (word1)
);

// File: tb/sim_dual_bit_rx.sv
module sim_dual_bit_rx;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_CYC    = 16;
   localparam int NVEC       = 4;
   // upper half: channel 0 word, lower half: channel 1 word
   localparam logic [31:0] VEC [NVEC] = '{
      32'hA5C3_0F0F, 32'hFFFF_0000, 32'h8001_7FFE, 32'h1234_EDCB};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  port_in = '0;
   logic        strobe = 1'b0;
   logic [15:0] word0, word1;
   logic        word_ready, from_watchdog;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int ready_cnt = 0;
   int last_ready = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_bit_rx #(.CLK_HZ(1600), .BIT_HZ(100)) u0 (
      .clk(clk), .rst(rst), .port_in(port_in), .strobe(strobe),
      .word0(word0), .word1(word1), .word_ready(word_ready),
      .from_watchdog(from_watchdog));

   task automatic tick();
      @(negedge clk);
      cyc++;
      if (word_ready) begin
         ready_cnt++;
         last_ready = cyc;
      end
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input bit b0, input bit b1, input logic [7:0] junk, input int low_cyc);
      port_in = (junk & 8'h9F) | {1'b0, b1, b0, 5'b0};
      strobe  = 1'b1;
      repeat (3) tick();
      strobe  = 1'b0;
      repeat (low_cyc) tick();
   endtask

   task automatic send_word(input logic [15:0] w0, input logic [15:0] w1,
                            input logic [7:0] junk, input int low_cyc);
      for (int i = 15; i >= 0; i--) send_bit(w0[i], w1[i], junk, low_cyc);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog timeout");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int rc;
      int t0;
      // R1: reset state
      repeat (4) tick();
      chk(word0 == 0 && word1 == 0, "R1 words in reset", {word0, word1}, 0);
      chk(!word_ready && !from_watchdog, "R1 flags in reset", {word_ready, from_watchdog}, 0);
      rst = 1'b0;
      tick();
      chk(word0 == 0 && word1 == 0 && !word_ready && !from_watchdog,
          "R1 after release", {word0, word1}, 0);

      // vector table: R2 mapping/ignored bits, R3 held strobe = one slot, R5 order
      for (int v = 0; v < NVEC; v++) begin
         rc = ready_cnt;
         send_word(VEC[v][31:16], VEC[v][15:0], (v % 2) ? 8'hFF : 8'h00, 5);
         chk(word0 == VEC[v][31:16], "R2 R5 word0", word0, VEC[v][31:16]);
         chk(word1 == VEC[v][15:0], "R2 R5 word1", word1, VEC[v][15:0]);
         chk(ready_cnt == rc + 1, "R3 R5 one ready per 16 strobes", ready_cnt - rc, 1);
         chk(!from_watchdog, "R7 strobe slots", from_watchdog, 0);
      end

      // R6: half a word collected, outputs unchanged
      rc = ready_cnt;
      for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b1, 8'h00, 5);
      chk(word0 == VEC[NVEC-1][31:16] && word1 == VEC[NVEC-1][15:0] && ready_cnt == rc,
          "R6 words held mid-word", word0, VEC[NVEC-1][31:16]);

      // R4: dropout completes the word with zeros even though port bits are ones
      port_in = 8'hFF;
      t0 = 0;
      while (ready_cnt == rc && t0 < 2000) begin tick(); t0++; end
      chk(word0 == 16'hFF00, "R4 fill word0", word0, 16'hFF00);
      chk(word1 == 16'hFF00, "R4 fill word1", word1, 16'hFF00);
      chk(from_watchdog, "R7 flag after watchdog slot", from_watchdog, 1);

      // R4: full dropout words are zero and spaced 16 bit periods
      rc = ready_cnt;
      t0 = last_ready;
      while (ready_cnt == rc && cyc < t0 + 2000) tick();
      chk(last_ready - t0 == 16 * BIT_CYC, "R4 dropout word spacing", last_ready - t0, 16 * BIT_CYC);
      chk(word0 == 0 && word1 == 0, "R4 dropout words zero", {word0, word1}, 0);

      // R3: strobes every 30 cycles (< 32) never let the watchdog insert a slot
      rc = ready_cnt;
      send_word(16'hC3A5, 16'h5A3C, 8'h00, 27);
      chk(word0 == 16'hC3A5, "R3 slow strobes word0", word0, 16'hC3A5);
      chk(word1 == 16'h5A3C, "R3 slow strobes word1", word1, 16'h5A3C);
      chk(ready_cnt == rc + 1, "R3 slow strobes ready count", ready_cnt - rc, 1);
      chk(!from_watchdog, "R7 flag cleared by strobe", from_watchdog, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule